// File: doc/BRIEF.md
# Quick Transfer Request Front-End

This block is the register front-end for one-off memory transfers. Software programs a transfer through five write-only registers: options, source address, destination address, index and transfer count. Each register can be reached at two addresses. The plain bank only stores the value. The alias bank stores the value and also submits a request. A full request therefore takes four plain writes and one final alias write. The block never modifies the stored values, so a single later alias write repeats the previous transfer.

A submitted request is presented as a descriptor on a valid/ready output toward the transfer engine. The descriptor copies all five values as they stand in the submitting cycle, including the word being written in that cycle. Every request runs frame-synchronised, and linking and count reload do not exist here. For this reason the frame-sync bit is forced in the descriptor and the unused option bits are cleared. The priority, element size, completion-interrupt enable and completion code are also decoded onto separate pins, so that the engine and the completion or chaining logic downstream can use them directly.

If an alias write lands while the output slot still holds an unaccepted descriptor, the register is still updated but the submit waits. The block remembers a single pending submit. When the slot frees, it issues one descriptor built from the register contents of that cycle.

Top module: `qxfer_front`

## Requirements
- R1: After reset `req_valid` is 0 and all five registers read as zero inside any later descriptor.
- R2: A write with `wr_addr[3]`=0 (plain bank) stores `wr_data` into register `wr_addr[2:0]` and never raises `req_valid`.
- R3: A write with `wr_addr[3]`=1 (alias bank) and an index 0..4 (0 options, 1 source, 2 destination, 3 index, 4 count) stores the word. If the slot is free or being accepted in that cycle, `req_valid` is 1 from the next cycle. The descriptor then holds all five values, including the new word.
- R4: The descriptor options word `req_opts` equals the stored options with bit 0 forced to 1 and bits [15:1] cleared. `req_prio`, `req_esize`, `req_irq_en` and `req_code` carry option bits [31:29], [28:27], [20] and [19:16].
- R5: The stored values are never altered by a submit. A second alias write of the same word produces an identical descriptor.
- R6: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and every descriptor output holds its value.
- R7: An alias write while the slot is held stores the word and marks one pending submit. Further alias writes before the slot frees merge into it. In the cycle of acceptance the slot reloads from the register contents of that cycle, and exactly one descriptor follows.
- R8: Writes with index 5..7, in either bank, change no register and submit nothing.
- R9: Plain writes made while a descriptor is held do not change that descriptor.
- R10: Index word: frame index in bits [31:16] and element index in bits [15:0]. Count word: frame count in bits [31:16] and element count in bits [15:0]. The descriptor outputs `req_frm_idx`, `req_elem_idx`, `req_frm_cnt` and `req_elem_cnt` follow this split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Bit 3 selects the alias bank; bits 2:0 select the register |
| wr_data | input | 32 | Write data |
| req_ready | input | 1 | Transfer engine accepts the descriptor |
| req_valid | output | 1 | Descriptor present |
| req_opts | output | 32 | Cleaned options word |
| req_prio | output | 3 | Priority field |
| req_esize | output | 2 | Element size field |
| req_irq_en | output | 1 | Completion interrupt enable |
| req_code | output | 4 | Completion code for interrupt or chaining |
| req_src | output | 32 | Source start address |
| req_dst | output | 32 | Destination start address |
| req_frm_idx | output | 16 | Frame index |
| req_elem_idx | output | 16 | Element index |
| req_frm_cnt | output | 16 | Frame count |
| req_elem_cnt | output | 16 | Element count |

## Verification
The bench builds the block with its default 32-bit data word and 4-bit write address. This exposes the full option word, so every decoded field and the cleared reserved range can be compared bit for bit. It also leaves three spare register indices in each bank for the ignored-address cases. Because the engine-side ready is held low on demand, the bench can reach the held-slot cases: an alias write against a busy slot, several merged alias writes, and plain writes that must not disturb a waiting descriptor.

// File: rtl/qxfer_pkg.sv
package qxfer_pkg;

  localparam int NUM_REGS = 5;

  typedef enum logic [2:0] {
    SEL_OPTS = 3'd0,
    SEL_SRC  = 3'd1,
    SEL_DST  = 3'd2,
    SEL_IDX  = 3'd3,
    SEL_CNT  = 3'd4
  } reg_sel_e;

  // Every request runs frame-synchronised: bit 0 forced, bits [15:1] unused.
  function automatic logic [31:0] clean_opts(input logic [31:0] raw);
    return {raw[31:16], 15'd0, 1'b1};
  endfunction

  function automatic logic [2:0] opt_prio(input logic [31:0] o);
    return o[31:29];
  endfunction

  function automatic logic [1:0] opt_esize(input logic [31:0] o);
    return o[28:27];
  endfunction

  function automatic logic opt_irq_en(input logic [31:0] o);
    return o[20];
  endfunction

  function automatic logic [3:0] opt_code(input logic [31:0] o);
    return o[19:16];
  endfunction

endpackage

// File: rtl/qxfer_regs.sv
module qxfer_regs #(
  parameter int DATA_W = 32,
  parameter int NREG   = 5,
  parameter int SEL_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [DATA_W-1:0]           wr_data,
  output logic                        sel_ok,
  output logic [NREG-1:0][DATA_W-1:0] regs_next
);

  logic [NREG-1:0][DATA_W-1:0] regs_q;

  assign sel_ok = (32'(wr_sel) < NREG);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit          = wr_en && (32'(wr_sel) == g);
    assign regs_next[g] = hit ? wr_data : regs_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= regs_next[g];
    end
  end

endmodule

// File: rtl/qxfer_slot.sv
module qxfer_slot #(
  parameter int DATA_W = 32,
  parameter int NREG   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        submit_hit,
  input  logic                        req_ready,
  input  logic [NREG-1:0][DATA_W-1:0] regs_next,
  output logic                        req_valid,
  output logic                        pend,
  output logic                        load,
  output logic [NREG-1:0][DATA_W-1:0] desc_q
);

  logic slot_free;

  assign slot_free = !req_valid || req_ready;
  assign load      = slot_free && (submit_hit || pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      pend      <= 1'b0;
      desc_q    <= '0;
    end else begin
      if (load)            req_valid <= 1'b1;
      else if (req_ready)  req_valid <= 1'b0;

      if (load)            pend <= 1'b0;
      else if (submit_hit) pend <= 1'b1;

      if (load)            desc_q <= regs_next;
    end
  end

endmodule

// File: rtl/qxfer_front.sv
module qxfer_front
  import qxfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [31:0]       req_opts,
  output logic [2:0]        req_prio,
  output logic [1:0]        req_esize,
  output logic              req_irq_en,
  output logic [3:0]        req_code,
  output logic [DATA_W-1:0] req_src,
  output logic [DATA_W-1:0] req_dst,
  output logic [HALF_W-1:0] req_frm_idx,
  output logic [HALF_W-1:0] req_elem_idx,
  output logic [HALF_W-1:0] req_frm_cnt,
  output logic [HALF_W-1:0] req_elem_cnt
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SEL_W  = ADDR_W - 1;

  logic                            wr_bank;
  logic                            sel_ok;
  logic                            submit_hit;
  logic                            submit_pend;
  logic                            slot_load;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_next;
  logic [NUM_REGS-1:0][DATA_W-1:0] desc_q;
  logic [31:0]                     opts_raw;

  assign wr_bank    = wr_addr[ADDR_W-1];
  assign submit_hit = wr_en && wr_bank && sel_ok;

  qxfer_regs #(.DATA_W(DATA_W), .NREG(NUM_REGS), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_addr[SEL_W-1:0]),
    .wr_data   (wr_data),
    .sel_ok    (sel_ok),
    .regs_next (regs_next)
  );

  qxfer_slot #(.DATA_W(DATA_W), .NREG(NUM_REGS)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .submit_hit (submit_hit),
    .req_ready  (req_ready),
    .regs_next  (regs_next),
    .req_valid  (req_valid),
    .pend       (submit_pend),
    .load       (slot_load),
    .desc_q     (desc_q)
  );

  assign opts_raw     = desc_q[SEL_OPTS][31:0];
  assign req_opts     = clean_opts(opts_raw);
  assign req_prio     = opt_prio(opts_raw);
  assign req_esize    = opt_esize(opts_raw);
  assign req_irq_en   = opt_irq_en(opts_raw);
  assign req_code     = opt_code(opts_raw);
  assign req_src      = desc_q[SEL_SRC];
  assign req_dst      = desc_q[SEL_DST];
  assign req_frm_idx  = desc_q[SEL_IDX][DATA_W-1:HALF_W];
  assign req_elem_idx = desc_q[SEL_IDX][HALF_W-1:0];
  assign req_frm_cnt  = desc_q[SEL_CNT][DATA_W-1:HALF_W];
  assign req_elem_cnt = desc_q[SEL_CNT][HALF_W-1:0];

endmodule

// File: rtl/qxfer_front_chk.sv
module qxfer_front_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_bank,
  input logic              submit_hit,
  input logic              submit_pend,
  input logic              slot_load,
  input logic              req_ready,
  input logic              req_valid,
  input logic [31:0]       req_opts,
  input logic [DATA_W-1:0] req_src,
  input logic [DATA_W-1:0] req_dst
);

  // R2: a plain write with nothing queued never produces a request
  assert_plain_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bank && !req_valid && !submit_pend) |=> !req_valid);

  // R3: an alias write against a free slot yields a request next cycle
  assert_alias_submits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (submit_hit && (!req_valid || req_ready)) |=> req_valid);

  // R4: a presented descriptor is always frame-synchronised, reserved bits clear
  assert_opts_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_opts[0] && (req_opts[15:1] == 15'd0)));

  // R6: a held descriptor stays valid and unchanged
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_opts)));

  // R7: an alias write against a held slot is remembered
  assert_busy_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (submit_hit && req_valid && !req_ready) |=> submit_pend);

  // R7: a pending submit is served as soon as the slot is accepted
  assert_pend_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (submit_pend && req_valid && req_ready) |-> slot_load);

endmodule

bind qxfer_front qxfer_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_bank     (wr_bank),
  .submit_hit  (submit_hit),
  .submit_pend (submit_pend),
  .slot_load   (slot_load),
  .req_ready   (req_ready),
  .req_valid   (req_valid),
  .req_opts    (req_opts),
  .req_src     (req_src),
  .req_dst     (req_dst)
);

// File: tb/qxfer_front_tb.sv
module qxfer_front_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_ready = 1'b1;
  logic        req_valid;
  logic [31:0] req_opts;
  logic [2:0]  req_prio;
  logic [1:0]  req_esize;
  logic        req_irq_en;
  logic [3:0]  req_code;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_frm_idx, req_elem_idx, req_frm_cnt, req_elem_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0]  model [5];
  logic [159:0] exp_q [$];

  always #4 clk = ~clk;

  qxfer_front u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_ready(req_ready), .req_valid(req_valid), .req_opts(req_opts),
    .req_prio(req_prio), .req_esize(req_esize), .req_irq_en(req_irq_en),
    .req_code(req_code), .req_src(req_src), .req_dst(req_dst),
    .req_frm_idx(req_frm_idx), .req_elem_idx(req_elem_idx),
    .req_frm_cnt(req_frm_cnt), .req_elem_cnt(req_elem_cnt)
  );

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected descriptor from the bench's register model
  function automatic logic [159:0] model_desc();
    logic [31:0] o;
    o = {model[0][31:16], 15'd0, 1'b1};
    return {o, model[1], model[2], model[3], model[4]};
  endfunction

  task automatic wr(input bit alias_bank, input int sel, input logic [31:0] d, input bit push);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {alias_bank, 3'(sel)}; wr_data = d;
    if (sel < 5) model[sel] = d;
    if (push) exp_q.push_back(model_desc());
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Monitor: samples late in the cycle, pops on each handshake
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected descriptor", 160'(req_src), 160'hdead);
        end else begin
          logic [159:0] e;
          e = exp_q.pop_front();
          check("R3/R10 descriptor",
                {req_opts, req_src, req_dst, req_frm_idx, req_elem_idx, req_frm_cnt, req_elem_cnt}, e);
          check("R4 decoded fields",
                160'({req_prio, req_esize, req_irq_en, req_code}),
                160'({e[159:157], e[156:155], e[148], e[147:144]}));
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 160'(req_valid), 160'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1: registers zero after reset, seen through the first descriptor
    wr(1, 4, 32'h0002_0007, 1);
    @(negedge clk);

    // R2: plain writes submit nothing
    wr(0, 0, 32'hA59F_FFFE, 0);
    check("R2 plain opts no submit", 160'(req_valid), 160'(0));
    wr(0, 1, 32'h1000_0000, 0);
    wr(0, 2, 32'h2000_0040, 0);
    wr(0, 3, 32'h0010_0004, 0);
    check("R2 plain no submit", 160'(req_valid), 160'(0));

    // R3, R10: alias write of the count completes the request
    wr(1, 4, 32'h0004_0003, 1);
    // R5: identical repeat with the same word
    wr(1, 4, 32'h0004_0003, 1);
    // R3, R4: alias write of the options word
    wr(1, 0, 32'h4E7A_8001, 1);
    @(negedge clk);

    // R8: spare indices do nothing in either bank
    wr(1, 6, 32'hFFFF_FFFF, 0);
    check("R8 alias spare index", 160'(req_valid), 160'(0));
    wr(0, 7, 32'hFFFF_FFFF, 0);
    wr(1, 5, 32'hFFFF_FFFF, 0);
    check("R8 spare index quiet", 160'(req_valid), 160'(0));
    wr(1, 1, 32'h3000_0000, 1);   // registers still the model's
    @(negedge clk);

    // R6, R9: held descriptor stays put while plain writes change registers
    req_ready = 1'b0;
    wr(1, 2, 32'h5555_0000, 1);
    wr(0, 1, 32'h7777_7777, 0);
    repeat (3) @(negedge clk);
    check("R6 held valid", 160'(req_valid), 160'(1));
    check("R9 held src", 160'(req_src), 160'(32'h3000_0000));
    check("R6 held dst", 160'(req_dst), 160'(32'h5555_0000));
    req_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 released", 160'(req_valid), 160'(0));

    // R7: busy alias writes merge into one pending submit
    req_ready = 1'b0;
    wr(1, 3, 32'h0020_0008, 1);            // fills the slot
    wr(1, 1, 32'h8000_0000, 0);            // pending
    wr(1, 2, 32'h9000_0000, 0);            // merged
    wr(0, 3, 32'h0030_000C, 0);            // plain, seen at reload
    exp_q.push_back(model_desc());
    check("R7 still held", 160'(req_src), 160'(32'h7777_7777));
    req_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 exactly one follow-up", 160'(req_valid), 160'(0));
    check("R3 queue drained", 160'(exp_q.size()), 160'(0));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule